// File: doc/BRIEF.md
# Device Power-State Controller

This block is the power-management state machine of a memory-mapped peripheral. It has one normal state and two low-power states. The host moves it into a low-power state by writing a 2-bit mode field in the power-control register. While the block sleeps, the clock enables for the internal modules are withdrawn, and host accesses are gated. The only way back to normal is a write of any value to a fixed test register. Clock restart is modelled as a fixed delay before the ready flag returns.

In the first low-power state the PHY-side clock keeps running, and frame-detector pulses (wake frame, magic packet) are monitored. A detection records a wake status code and sets an interrupt status bit. It can raise the power-management event output and the host interrupt when the matching enables are set. After reset and after every wake, host writes are ignored until the host has completed one honoured read.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset, ready_o is 1, every module clock enable is 1, pme_o and irq_o are 0, and the power-control register (address 0) reads 0x4: bit 2 is ready and all other fields are zero.
- R2: An honoured write to address 0 with bits[1:0]=01 enters the first sleep state (D1), and with 10 enters the second sleep state (D2). ready_o falls on the next cycle. Bits[1:0] read back as the current mode (00 normal, 01 D1, 10 D2). The value 11 is ignored.
- R3: Clock enables (bit 0 = PHY-side module) are all 1 in the normal and waking states. In D1 only bit 0 is 1. In D2 all are 0.
- R4: While ready is 0, only reads of address 0 return data. Other reads return 0, and writes other than the test-register write are dropped. Any blocked access sets the sticky error bit 7 of address 0.
- R5: In D1 or D2, a write of any data to the test register (address 3) resets the mode field to 00. ready_o then rises exactly WAKE_DLY cycles after the write's clock edge. In the normal state the same write has no effect on ready_o.
- R6: The test-register wake works whether or not any wake event was detected.
- R7: A detector pulse in D1 sets the wake status field bits[6:5] of address 0 to 10, and sets interrupt status bit 0 of address 1. Pulses in D2 or in the normal state change neither field.
- R8: pme_o is 1 exactly while the wake status is 10 and both the event-output enable (bit 3) and the wake-on-LAN enable (bit 4) of address 0 are 1.
- R9: irq_o is 1 exactly while interrupt status bit 0 and interrupt enable bit 0 (address 2) are both 1. The status bit is set regardless of the event-output enable.
- R10: After reset or a wake, host writes have no effect until one honoured read has occurred.
- R11: The configuration registers (enables, interrupt enable, scratch at address 4) keep their contents across D1, D2 and wake.
- R12: Writing 1 to bit 6 of address 0 clears the wake status field, and writing 1 to bit 7 clears the error bit. Writing 1 to bit 0 of address 1 clears the interrupt status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, combinational, zero when not honoured |
| wake_frame_i | input | 1 | Wake-frame detected pulse |
| magic_pkt_i | input | 1 | Magic-packet detected pulse |
| ready_o | output | 1 | Device ready |
| mod_clk_en_o | output | N_MOD | Module clock enables, bit 0 PHY-side |
| pme_o | output | 1 | Power-management event output |
| irq_o | output | 1 | Host interrupt |

## Verification
A wrong state register shows up on the cycle after the mode write. ready_o and the clock enables change together, and the mode readback of address 0 names the state. An error in the wake counter moves the rising edge of ready_o away from WAKE_DLY cycles, so the ready level is sampled on both sides of that edge. A missing or stuck write-arming flag appears only through a later read: a dropped scratch write returns the old value, and a write that should have been dropped returns the new one.

// File: rtl/pwr_pkg.sv
// Package: shared state encoding, register addresses and field positions
// for the power-state controller. Assumes DATA_W <= 32 where the test
// pattern is used.
package pwr_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_SLEEP1 = 2'd1,
        ST_SLEEP2 = 2'd2,
        ST_WAKING = 2'd3
    } pwr_state_t;

    localparam int unsigned A_CTRL    = 0;
    localparam int unsigned A_INTSTS  = 1;
    localparam int unsigned A_INTEN   = 2;
    localparam int unsigned A_TEST    = 3;
    localparam int unsigned A_SCRATCH = 4;

    localparam logic [1:0] MODE_D0 = 2'b00;
    localparam logic [1:0] MODE_D1 = 2'b01;
    localparam logic [1:0] MODE_D2 = 2'b10;
    localparam logic [1:0] WSTS_HIT = 2'b10;

    localparam int unsigned B_READY  = 2;
    localparam int unsigned B_PMEEN  = 3;
    localparam int unsigned B_WOLEN  = 4;
    localparam int unsigned B_WSTS   = 5;
    localparam int unsigned B_WSCLR  = 6;
    localparam int unsigned B_ERR    = 7;

    localparam int unsigned PHY_IDX = 0;
    localparam logic [31:0] TEST_PATTERN = 32'h8765_4321;
endpackage

// File: rtl/pwr_access_gate.sv
// Access gate: decides which host strobes are honoured given readiness
// and the low-power state, detects the wake write, and holds the
// write-arming flag that needs one honoured read after reset or wake.
// Assumes host_rd and host_wr are never high in the same cycle.
module pwr_access_gate
    import pwr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              ready,
    input  logic              low_power,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              wake_req,
    output logic              blocked,
    output logic              armed
);
    logic is_ctrl;
    logic is_test;

    // Address decode and honour decisions for this cycle.
    always_comb begin
        is_ctrl  = (addr == ADDR_W'(A_CTRL));
        is_test  = (addr == ADDR_W'(A_TEST));
        rd_ok    = rd_en && (ready || is_ctrl);
        wake_req = wr_en && low_power && is_test;
        wr_ok    = wr_en && ready && armed;
        blocked  = (rd_en && !rd_ok) || (wr_en && !ready && !wake_req);
    end

    // Write arming: cleared by reset and wake, set by any honoured read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wake_req) begin
            armed <= 1'b0;
        end else if (rd_ok) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/pwr_fsm.sv
// Power-state sequencer: holds the current state, counts the clock
// restart delay after a wake, and drives ready and module clock enables.
// Assumes WAKE_DLY >= 1 and N_MOD >= 1.
module pwr_fsm
    import pwr_pkg::*;
#(
    parameter int WAKE_DLY = 4,
    parameter int N_MOD    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_d1,
    input  logic             go_d2,
    input  logic             wake_req,
    output pwr_state_t       state,
    output logic             ready,
    output logic             low_power,
    output logic [N_MOD-1:0] clk_en
);
    localparam int CNT_W = $clog2(WAKE_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_DLY - 1);

    logic [CNT_W-1:0] dly_cnt;
    logic             phy_run;
    logic             full_run;

    // State transitions and restart-delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ACTIVE;
            dly_cnt <= '0;
        end else begin
            case (state)
                ST_ACTIVE: begin
                    if (go_d1) begin
                        state <= ST_SLEEP1;
                    end else if (go_d2) begin
                        state <= ST_SLEEP2;
                    end
                end
                ST_SLEEP1, ST_SLEEP2: begin
                    if (wake_req) begin
                        state   <= ST_WAKING;
                        dly_cnt <= '0;
                    end
                end
                default: begin
                    if (dly_cnt == CNT_LAST) begin
                        state <= ST_ACTIVE;
                    end else begin
                        dly_cnt <= dly_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Status decode from the state.
    always_comb begin
        ready     = (state == ST_ACTIVE);
        low_power = (state == ST_SLEEP1) || (state == ST_SLEEP2);
        full_run  = (state == ST_ACTIVE) || (state == ST_WAKING);
        phy_run   = (state != ST_SLEEP2);
    end

    // One enable per module; the PHY-side module keeps its clock in D1.
    for (genvar g = 0; g < N_MOD; g++) begin : g_clken
        if (g == PHY_IDX) begin : g_phy
            assign clk_en[g] = phy_run;
        end else begin : g_other
            assign clk_en[g] = full_run;
        end
    end
endmodule

// File: rtl/pwr_regs.sv
// Register file: power-control fields, interrupt status and enable,
// scratch configuration word and the read multiplexer. Also forms the
// sleep requests, the event output and the interrupt line.
// Assumes the gate has already qualified rd_ok, wr_ok and blocked.
module pwr_regs
    import pwr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic              blocked,
    input  logic              detect,
    input  logic [1:0]        mode_rd,
    input  logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              go_d1,
    output logic              go_d2,
    output logic              pme_en,
    output logic              wol_en,
    output logic              int_en,
    output logic              pme_o,
    output logic              irq_o
);
    logic [1:0]        wsts;
    logic              acc_err;
    logic              pme_int;
    logic [DATA_W-1:0] scratch;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_ctrl;
    logic              wr_ists;
    logic              wr_ien;
    logic              wr_scr;

    // Write strobes per register and sleep requests.
    always_comb begin
        wr_ctrl = wr_ok && (addr == ADDR_W'(A_CTRL));
        wr_ists = wr_ok && (addr == ADDR_W'(A_INTSTS));
        wr_ien  = wr_ok && (addr == ADDR_W'(A_INTEN));
        wr_scr  = wr_ok && (addr == ADDR_W'(A_SCRATCH));
        go_d1   = wr_ctrl && (wdata[1:0] == MODE_D1);
        go_d2   = wr_ctrl && (wdata[1:0] == MODE_D2);
    end

    // Enable bits and scratch word, written only by honoured writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pme_en  <= 1'b0;
            wol_en  <= 1'b0;
            int_en  <= 1'b0;
            scratch <= '0;
        end else begin
            if (wr_ctrl) begin
                pme_en <= wdata[B_PMEEN];
                wol_en <= wdata[B_WOLEN];
            end
            if (wr_ien) begin
                int_en <= wdata[0];
            end
            if (wr_scr) begin
                scratch <= wdata;
            end
        end
    end

    // Sticky status bits: detection and blocked accesses set, W1C clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsts    <= MODE_D0;
            acc_err <= 1'b0;
            pme_int <= 1'b0;
        end else begin
            if (detect) begin
                wsts <= WSTS_HIT;
            end else if (wr_ctrl && wdata[B_WSCLR]) begin
                wsts <= 2'b00;
            end
            if (blocked) begin
                acc_err <= 1'b1;
            end else if (wr_ctrl && wdata[B_ERR]) begin
                acc_err <= 1'b0;
            end
            if (detect) begin
                pme_int <= 1'b1;
            end else if (wr_ists && wdata[0]) begin
                pme_int <= 1'b0;
            end
        end
    end

    // Read multiplexer; unhonoured reads return zero.
    always_comb begin
        rd_mux = '0;
        case (addr)
            ADDR_W'(A_CTRL): begin
                rd_mux[1:0]            = mode_rd;
                rd_mux[B_READY]        = ready;
                rd_mux[B_PMEEN]        = pme_en;
                rd_mux[B_WOLEN]        = wol_en;
                rd_mux[B_WSTS+1:B_WSTS] = wsts;
                rd_mux[B_ERR]          = acc_err;
            end
            ADDR_W'(A_INTSTS):  rd_mux[0] = pme_int;
            ADDR_W'(A_INTEN):   rd_mux[0] = int_en;
            ADDR_W'(A_TEST):    rd_mux = TEST_PATTERN[DATA_W-1:0];
            ADDR_W'(A_SCRATCH): rd_mux = scratch;
            default:            rd_mux = '0;
        endcase
        rdata = rd_ok ? rd_mux : '0;
    end

    // Event output and host interrupt.
    always_comb begin
        pme_o = (wsts == WSTS_HIT) && pme_en && wol_en;
        irq_o = pme_int && int_en;
    end
endmodule

// File: rtl/pwr_state_ctrl.sv
// Top: power-state controller for a memory-mapped peripheral. Wires the
// access gate, the state sequencer and the register file. Wake detection
// is armed only in D1. Assumes single-cycle host strobes.
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int N_MOD    = 3,
    parameter int WAKE_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              wake_frame_i,
    input  logic              magic_pkt_i,
    output logic              ready_o,
    output logic [N_MOD-1:0]  mod_clk_en_o,
    output logic              pme_o,
    output logic              irq_o
);
    pwr_state_t cur_state;
    logic       low_power;
    logic       rd_ok;
    logic       wr_ok;
    logic       wake_req;
    logic       blocked;
    logic       wr_armed;
    logic       go_d1;
    logic       go_d2;
    logic       detect;
    logic [1:0] mode_rd;
    logic       pme_en;
    logic       wol_en;
    logic       int_en;

    // Mode readback and D1-only detection.
    always_comb begin
        case (cur_state)
            ST_SLEEP1: mode_rd = MODE_D1;
            ST_SLEEP2: mode_rd = MODE_D2;
            default:   mode_rd = MODE_D0;
        endcase
        detect = (wake_frame_i || magic_pkt_i) && (cur_state == ST_SLEEP1);
    end

    pwr_access_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (host_addr),
        .rd_en     (host_rd),
        .wr_en     (host_wr),
        .ready     (ready_o),
        .low_power (low_power),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .wake_req  (wake_req),
        .blocked   (blocked),
        .armed     (wr_armed)
    );

    pwr_fsm #(.WAKE_DLY(WAKE_DLY), .N_MOD(N_MOD)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_d1     (go_d1),
        .go_d2     (go_d2),
        .wake_req  (wake_req),
        .state     (cur_state),
        .ready     (ready_o),
        .low_power (low_power),
        .clk_en    (mod_clk_en_o)
    );

    pwr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok),
        .blocked (blocked),
        .detect  (detect),
        .mode_rd (mode_rd),
        .ready   (ready_o),
        .rdata   (host_rdata),
        .go_d1   (go_d1),
        .go_d2   (go_d2),
        .pme_en  (pme_en),
        .wol_en  (wol_en),
        .int_en  (int_en),
        .pme_o   (pme_o),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
// Checker: temporal properties of the power-state controller, bound
// into every instance of the top module.
module pwr_state_ctrl_chk
    import pwr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int N_MOD  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              ready_o,
    input logic [N_MOD-1:0]  mod_clk_en_o,
    input logic              pme_o,
    input logic              irq_o,
    input logic              pme_en,
    input logic              wol_en,
    input logic              int_en,
    input logic              wr_armed,
    input pwr_state_t        cur_state
);
    assert_blocked_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && host_rd && host_addr != ADDR_W'(A_CTRL)) |-> host_rdata == '0);

    assert_sleep_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && wr_armed && host_wr && host_addr == ADDR_W'(A_CTRL)
         && (host_wdata[1:0] == MODE_D1 || host_wdata[1:0] == MODE_D2)) |=> !ready_o);

    assert_mode3_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && host_wr && host_addr == ADDR_W'(A_CTRL) && host_wdata[1:0] == 2'b11)
        |=> ready_o);

    assert_ready_clocks_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (&mod_clk_en_o));

    assert_d2_clocks_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SLEEP2) |-> (mod_clk_en_o == '0));

    assert_ready_after_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(cur_state) == ST_WAKING);

    assert_pme_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pme_o |-> (pme_en && wol_en));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> int_en);

    assert_unarmed_write_no_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !wr_armed && host_wr) |=> ready_o);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_MOD(N_MOD)
) u_chk (.*);

// File: tb/pwr_state_ctrl_tb.sv
// Bench: vector table for normal-state register traffic, then directed
// tests for sleep, gating, wake timing, detection and clearing.
module pwr_state_ctrl_tb;
    localparam int AW = 3;
    localparam int DW = 32;
    localparam int NM = 3;
    localparam int WD = 4;
    localparam logic [2:0] CTRL = 3'd0, ISTS = 3'd1, IEN = 3'd2, TEST = 3'd3, SCR = 3'd4;
    localparam int NV = 11;
    // {is_write, addr, data, expected read}
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, CTRL, 32'h0,         32'h0000_0004},
        {1'b0, SCR,  32'h0,         32'h0000_0000},
        {1'b1, SCR,  32'hA5A5_0001, 32'h0},
        {1'b0, SCR,  32'h0,         32'hA5A5_0001},
        {1'b0, TEST, 32'h0,         32'h8765_4321},
        {1'b1, IEN,  32'h1,         32'h0},
        {1'b0, IEN,  32'h0,         32'h0000_0001},
        {1'b1, CTRL, 32'h18,        32'h0},
        {1'b0, CTRL, 32'h0,         32'h0000_001C},
        {1'b1, CTRL, 32'h1B,        32'h0},
        {1'b0, CTRL, 32'h0,         32'h0000_001C}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          wake_frame_i = 1'b0;
    logic          magic_pkt_i = 1'b0;
    logic          ready_o;
    logic [NM-1:0] mod_clk_en_o;
    logic          pme_o;
    logic          irq_o;
    int            n_chk = 0;
    int            n_fail = 0;

    always #5 clk = ~clk;

    pwr_state_ctrl #(.ADDR_W(AW), .DATA_W(DW), .N_MOD(NM), .WAKE_DLY(WD)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .wake_frame_i(wake_frame_i), .magic_pkt_i(magic_pkt_i), .ready_o(ready_o),
        .mod_clk_en_o(mod_clk_en_o), .pme_o(pme_o), .irq_o(irq_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_addr = a;
        host_rd   = 1'b1;
        #1;
        check(host_rdata, exp, tag);
        @(posedge clk);
        #1 host_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    task automatic pulse(input bit magic);
        @(negedge clk);
        if (magic) magic_pkt_i = 1'b1; else wake_frame_i = 1'b1;
        @(posedge clk);
        #1;
        magic_pkt_i  = 1'b0;
        wake_frame_i = 1'b0;
    endtask

    // Wake write then ready timing: low at WD-1 negedges after the edge, high at WD.
    task automatic wake_and_time(input logic [31:0] d, input string tag);
        wr(TEST, d);
        for (int i = 0; i < WD; i++) begin
            @(negedge clk);
            if (i == WD - 1) check({31'b0, ready_o}, 32'd0, tag);
        end
        @(negedge clk);
        check({31'b0, ready_o}, 32'd1, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check({31'b0, ready_o}, 32'd1, "R1 ready");
        check({29'b0, mod_clk_en_o}, 32'h7, "R1 clk_en");
        check({30'b0, pme_o, irq_o}, 32'd0, "R1 pme/irq");
        // R10 write before any read is dropped (table entry 1 reads 0)
        wr(SCR, 32'h1234_5678);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
            else rd(VEC[i][66:64], VEC[i][31:0], $sformatf("R1/R2/R10/R11 vec%0d", i));
        end
        // R5 test write in normal state does not disturb ready
        wr(TEST, 32'h5);
        @(negedge clk);
        check({31'b0, ready_o}, 32'd1, "R5 test write when active");

        // Enter D1
        wr(CTRL, 32'h19);
        @(negedge clk);
        check({31'b0, ready_o}, 32'd0, "R2 ready falls in D1");
        check({29'b0, mod_clk_en_o}, 32'h1, "R3 D1 enables");
        rd(CTRL, 32'h19, "R2 mode readback D1");
        rd(SCR, 32'h0, "R4 blocked read zero");
        rd(CTRL, 32'h99, "R4 error bit set");
        wr(SCR, 32'hFFFF_FFFF);
        pulse(1'b0);
        @(negedge clk);
        check({31'b0, pme_o}, 32'd1, "R8 pme asserted");
        check({31'b0, irq_o}, 32'd1, "R9 irq asserted");
        rd(CTRL, 32'hD9, "R7 wake status 10");
        wake_and_time(32'hDEAD_BEEF, "R5 wake delay");
        wr(SCR, 32'h0BAD_0BAD);
        rd(SCR, 32'hA5A5_0001, "R11 R10 scratch kept, unarmed write dropped");
        rd(CTRL, 32'hDC, "R5 mode reset to 00");
        check({29'b0, mod_clk_en_o}, 32'h7, "R3 enables after wake");
        wr(CTRL, 32'hD8);
        @(negedge clk);
        check({31'b0, pme_o}, 32'd0, "R12 wake status cleared");
        wr(ISTS, 32'h1);
        @(negedge clk);
        check({31'b0, irq_o}, 32'd0, "R12 int status cleared");
        rd(CTRL, 32'h1C, "R12 ctrl after clears");

        // D2: no detection, wake without event
        wr(CTRL, 32'h1A);
        @(negedge clk);
        check({29'b0, mod_clk_en_o}, 32'h0, "R3 D2 enables");
        rd(CTRL, 32'h1A, "R2 mode readback D2");
        pulse(1'b1);
        @(negedge clk);
        check({31'b0, pme_o}, 32'd0, "R7 no detection in D2");
        wake_and_time(32'h0, "R6 wake without event");
        rd(CTRL, 32'h1C, "R7 status untouched in D2");
        rd(ISTS, 32'h0, "R7 int status untouched in D2");

        // D1 with event-output disabled and interrupt disabled
        wr(IEN, 32'h0);
        wr(CTRL, 32'h11);
        pulse(1'b1);
        @(negedge clk);
        check({31'b0, pme_o}, 32'd0, "R8 pme needs pme_en");
        check({31'b0, irq_o}, 32'd0, "R9 irq needs int_en");
        wake_and_time(32'h1, "R5 second wake");
        rd(ISTS, 32'h1, "R9 status set regardless of pme_en");
        rd(CTRL, 32'h54, "R7 status after D1 event");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule